// File: doc/BRIEF.md
# Guarded GPIO Pad Configuration Bank

This block holds the pad configuration for one general-purpose I/O port of eight pins. It has four per-pin control vectors: alternate-function select, pull-up enable, pull-down enable and digital enable. The four vectors go straight to the pad logic. Software reaches the bank through a small register bus with a write strobe, an address, 32-bit write data and registered read data.

Some pins carry functions that must not be switched off by accident. These are the debug-port pins and the non-maskable-interrupt pin. For these protected pins, a write to any of the four control vectors is kept only when two conditions both hold:

- a key register has been opened with a fixed 32-bit code;
- a per-pin commit mask allows that pin.

Pins that are not protected always take the written value. After reset the debug pins are handed to their alternate function, with pull-ups on and digital input enabled, so that a debugger can connect before software runs.

Each bit of a write is gated on its own. One write can therefore change some pins and leave others alone. The set of protected pins and the set of debug pins are parameters.

Top module: `gpio_cfg_guard`

## Requirements
- R1: After reset, the following values hold. Alternate-function select, pull-up and digital enable read 0x0F: debug pins 3:0 are set and all other bits are clear. Pull-down reads 0x00. The key register is closed. Every commit bit of a protected pin is 0.
- R2: Writing 0x4C4F434B to the key register (address 4) opens it. Writing any other value to address 4 closes it. Reading address 4 returns 1 while closed and 0 while open.
- R3: The commit register (address 5) stores write data only while the key is open, and it stores only the bits of protected pins. Bits of unprotected pins always read 1. With the default protected mask of 0x8F, the commit register therefore reads 0x70 after reset.
- R4: When the key is closed, or when the commit bit of a protected pin is 0, a write to any of the four control vectors leaves that pin's bit unchanged.
- R5: A write to any of the four control vectors always stores the bits of unprotected pins (4 to 6 by default), whatever the key and commit state.
- R6: Within one write, each bit is gated on its own. Permitted bits take the new value and blocked bits keep their old value.
- R7: When the key is open and a protected pin's commit bit is set, writing 0 to that pin's alternate-function bit drives that pin's output to 0, which selects plain GPIO use.
- R8: A read returns the stored value in the data bits 7:0 on the clock edge after the address is presented. The upper data bits are zero. The address map is:
  - 0: alternate-function select
  - 1: pull-up
  - 2: pull-down
  - 3: digital enable
  - 4: key
  - 5: commit
  - 6 and 7: read as 0
- R9: A control vector changes only on a write to its own address. Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, one cycle after the address |
| altf_o | output | 8 | Alternate-function select per pin |
| pullup_o | output | 8 | Pull-up enable per pin |
| pulldn_o | output | 8 | Pull-down enable per pin |
| digen_o | output | 8 | Digital enable per pin |

## Verification
The assertions check four things on every cycle:

- While the key is closed, no protected bit of any control vector changes and the commit mask stays the same.
- Unprotected bits always follow a write.
- The key opens only on the exact code, and the key readback reports the previous cycle's state.
- Without a write, nothing changes.

The bench scenarios show the rest against a behavioural model. These are the exact reset values, per-bit gating under mixed commit masks, a debug pin being released to GPIO, relocking after use, the full read map, and a reset in the middle of a run.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  // Register addresses
  localparam int unsigned SEL_ALTF   = 0;
  localparam int unsigned SEL_PULLUP = 1;
  localparam int unsigned SEL_PULLDN = 2;
  localparam int unsigned SEL_DIGEN  = 3;
  localparam int unsigned SEL_KEY    = 4;
  localparam int unsigned SEL_COMMIT = 5;
  localparam int unsigned NUM_CTL    = 4;

  // Code that opens the key register
  localparam logic [31:0] OPEN_CODE = 32'h4C4F_434B;

  typedef enum logic [1:0] {
    CTL_ALTF   = 2'd0,
    CTL_PULLUP = 2'd1,
    CTL_PULLDN = 2'd2,
    CTL_DIGEN  = 2'd3
  } ctl_idx_e;
endpackage

// File: rtl/gpio_cfg_rstsync.sv
module gpio_cfg_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_keyctl.sv
module gpio_cfg_keyctl
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned PINS      = 8,
  parameter int unsigned DATA_W    = 32,
  parameter logic [PINS-1:0] PROT_MASK = 8'h8F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_we,
  input  logic              commit_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              unlocked,
  output logic [PINS-1:0]   commit
);
  logic unlocked_q, unlocked_d;
  logic key_match;

  assign key_match = (wdata[31:0] == OPEN_CODE);

  always_comb begin
    unlocked_d = unlocked_q;
    if (key_we) unlocked_d = key_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlocked_q <= 1'b0;
    else        unlocked_q <= unlocked_d;
  end

  assign unlocked = unlocked_q;

  for (genvar i = 0; i < PINS; i++) begin : g_commit
    if (PROT_MASK[i]) begin : g_prot
      logic bit_q, bit_d, bit_en;
      assign bit_en = commit_we & unlocked_q;
      always_comb begin
        bit_d = bit_q;
        if (bit_en) bit_d = wdata[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign commit[i] = bit_q;
    end else begin : g_open
      assign commit[i] = 1'b1;
    end
  end
endmodule

// File: rtl/gpio_cfg_ctlreg.sv
module gpio_cfg_ctlreg #(
  parameter int unsigned PINS      = 8,
  parameter logic [PINS-1:0] PROT_MASK = 8'h8F,
  parameter logic [PINS-1:0] RST_VAL   = 8'h0F
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [PINS-1:0] wbits,
  input  logic            unlocked,
  input  logic [PINS-1:0] commit,
  output logic [PINS-1:0] q
);
  logic [PINS-1:0] permit;

  assign permit = ~PROT_MASK | ({PINS{unlocked}} & commit);

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    logic d, en;
    assign en = we & permit[i];
    always_comb begin
      d = q[i];
      if (en) d = wbits[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= RST_VAL[i];
      else        q[i] <= d;
    end
  end
endmodule

// File: rtl/gpio_cfg_rdport.sv
module gpio_cfg_rdport
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned PINS   = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_CTL*PINS-1:0]   ctl_flat,
  input  logic                      unlocked,
  input  logic [PINS-1:0]           commit,
  output logic [DATA_W-1:0]         rdata
);
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (int'(addr) < NUM_CTL) begin
      for (int k = 0; k < NUM_CTL; k++) begin
        if (int'(addr) == k) rd_d[PINS-1:0] = ctl_flat[k*PINS +: PINS];
      end
    end else if (int'(addr) == SEL_KEY) begin
      rd_d[0] = ~unlocked;
    end else if (int'(addr) == SEL_COMMIT) begin
      rd_d[PINS-1:0] = commit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned PINS      = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [PINS-1:0] PROT_MASK = 8'h8F,
  parameter logic [PINS-1:0] DBG_MASK  = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [PINS-1:0]   altf_o,
  output logic [PINS-1:0]   pullup_o,
  output logic [PINS-1:0]   pulldn_o,
  output logic [PINS-1:0]   digen_o
);
  localparam logic [NUM_CTL*PINS-1:0] RST_TABLE =
    {DBG_MASK, {PINS{1'b0}}, DBG_MASK, DBG_MASK};  // digen, pulldn, pullup, altf

  logic                    srst_n;
  logic                    unlocked;
  logic [PINS-1:0]         commit;
  logic [NUM_CTL*PINS-1:0] ctl_flat;
  logic                    key_we, commit_we;

  gpio_cfg_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign key_we    = wr_en & (int'(addr) == SEL_KEY);
  assign commit_we = wr_en & (int'(addr) == SEL_COMMIT);

  gpio_cfg_keyctl #(.PINS(PINS), .DATA_W(DATA_W), .PROT_MASK(PROT_MASK)) u_key (
    .clk(clk), .rst_n(srst_n), .key_we(key_we), .commit_we(commit_we),
    .wdata(wdata), .unlocked(unlocked), .commit(commit)
  );

  for (genvar r = 0; r < NUM_CTL; r++) begin : g_ctl
    logic we_r;
    assign we_r = wr_en & (int'(addr) == r);
    gpio_cfg_ctlreg #(
      .PINS(PINS), .PROT_MASK(PROT_MASK), .RST_VAL(RST_TABLE[r*PINS +: PINS])
    ) u_reg (
      .clk(clk), .rst_n(srst_n), .we(we_r), .wbits(wdata[PINS-1:0]),
      .unlocked(unlocked), .commit(commit), .q(ctl_flat[r*PINS +: PINS])
    );
  end

  gpio_cfg_rdport #(.PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(srst_n), .addr(addr), .ctl_flat(ctl_flat),
    .unlocked(unlocked), .commit(commit), .rdata(rdata)
  );

  assign altf_o   = ctl_flat[int'(CTL_ALTF)*PINS   +: PINS];
  assign pullup_o = ctl_flat[int'(CTL_PULLUP)*PINS +: PINS];
  assign pulldn_o = ctl_flat[int'(CTL_PULLDN)*PINS +: PINS];
  assign digen_o  = ctl_flat[int'(CTL_DIGEN)*PINS  +: PINS];
endmodule

// File: rtl/gpio_cfg_guard_chk.sv
module gpio_cfg_guard_chk
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned PINS      = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 3,
  parameter logic [PINS-1:0] PROT_MASK = 8'h8F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [PINS-1:0]   altf,
  input logic [PINS-1:0]   pu,
  input logic [PINS-1:0]   pd,
  input logic [PINS-1:0]   den,
  input logic              unlocked,
  input logic [PINS-1:0]   commit
);
  logic [4*PINS-1:0] all_ctl;
  logic [4*PINS-1:0] prot4;
  assign all_ctl = {den, pd, pu, altf};
  assign prot4   = {4{PROT_MASK}};

  assert_prot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ((all_ctl & prot4) == ($past(all_ctl) & prot4)));

  assert_commit_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(commit));

  assert_unprot_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == SEL_ALTF) |=>
      ((altf & ~PROT_MASK) == ($past(wdata[PINS-1:0]) & ~PROT_MASK)));

  assert_bitwise_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == SEL_PULLDN && unlocked) |=>
      (pd == (($past(wdata[PINS-1:0]) & ($past(commit) | ~PROT_MASK)) |
              ($past(pd) & ~($past(commit) | ~PROT_MASK)))));

  assert_key_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(addr) == SEL_KEY) |=> (unlocked == ($past(wdata[31:0]) == OPEN_CODE)));

  assert_key_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) == SEL_KEY) |=> (rdata[0] == !$past(unlocked) && rdata[DATA_W-1:1] == '0));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(all_ctl));
endmodule

bind gpio_cfg_guard gpio_cfg_guard_chk #(
  .PINS(PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROT_MASK(PROT_MASK)
) chk_i (
  .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .altf(altf_o), .pu(pullup_o), .pd(pulldn_o), .den(digen_o),
  .unlocked(unlocked), .commit(commit)
);

// File: tb/gpio_cfg_guard_tb.sv
`timescale 1ns/1ps
module gpio_cfg_guard_tb_top;
  localparam logic [7:0]  PROT = 8'h8F;
  localparam logic [31:0] CODE = 32'h4C4F434B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  altf_o, pullup_o, pulldn_o, digen_o;

  always #10 clk = ~clk;

  gpio_cfg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .altf_o(altf_o), .pullup_o(pullup_o),
    .pulldn_o(pulldn_o), .digen_o(digen_o)
  );

  // Behavioural reference model
  logic [7:0]  m_reg [4];
  logic [7:0]  m_com;
  bit          m_open;
  logic [31:0] m_rd;
  int          rcnt;
  int          n_chk = 0, n_fail = 0;
  string       cur_req = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 8'h0F; m_reg[1] = 8'h0F; m_reg[2] = 8'h00; m_reg[3] = 8'h0F;
      m_com = 8'h00; m_open = 0; m_rd = 0; rcnt = 0;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      case (addr)
        3'd0, 3'd1, 3'd2, 3'd3: m_rd = {24'h0, m_reg[addr]};
        3'd4: m_rd = m_open ? 32'd0 : 32'd1;
        3'd5: m_rd = {24'h0, m_com | ~PROT};
        default: m_rd = 32'd0;
      endcase
      if (wr_en) begin
        if (addr < 3'd4) begin
          for (int b = 0; b < 8; b++)
            if (!PROT[b] || (m_open && m_com[b])) m_reg[addr][b] = wdata[b];
        end else if (addr == 3'd4) begin
          m_open = (wdata == CODE);
        end else if (addr == 3'd5 && m_open) begin
          m_com = wdata[7:0] & PROT;
        end
      end
    end
  end

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("altf",   {24'h0, altf_o},   {24'h0, m_reg[0]});
      check("pullup", {24'h0, pullup_o}, {24'h0, m_reg[1]});
      check("pulldn", {24'h0, pulldn_o}, {24'h0, m_reg[2]});
      check("digen",  {24'h0, digen_o},  {24'h0, m_reg[3]});
      check("rdata",  rdata, m_rd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    @(negedge clk); wr_en = 1'b0; addr = a;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    cur_req = "R1";
    do_reset();
    @(negedge clk);
    check("R1 altf reset", {24'h0, altf_o}, 32'h0F);
    check("R1 pulldn reset", {24'h0, pulldn_o}, 32'h00);
    rd(3'd4); check("R1 key closed", rdata, 32'd1);
    rd(3'd5); check("R1 commit reset", rdata, 32'h70);

    cur_req = "R8";
    for (int a = 0; a < 8; a++) rd(3'(a));

    cur_req = "R4";
    wr(3'd0, 32'h00);
    wr(3'd2, 32'hFF);
    cur_req = "R6";
    wr(3'd0, 32'hF0);
    check("R6 altf mixed locked", {24'h0, altf_o}, 32'h7F);

    cur_req = "R3";
    wr(3'd5, 32'hFF); rd(3'd5);

    cur_req = "R2";
    wr(3'd4, CODE); rd(3'd4);
    check("R2 key open", rdata, 32'd0);
    wr(3'd4, 32'h1234_5678); rd(3'd4);
    check("R2 key reclosed", rdata, 32'd1);
    wr(3'd4, CODE);

    cur_req = "R3";
    wr(3'd5, 32'h81); rd(3'd5);
    check("R3 commit partial", rdata, 32'hF1);

    cur_req = "R7";
    wr(3'd0, 32'h70);
    check("R7 pin0 to gpio", {31'h0, altf_o[0]}, 32'd0);
    cur_req = "R6";
    wr(3'd1, 32'h00); wr(3'd2, 32'hFF); wr(3'd3, 32'h55);

    cur_req = "R4";
    wr(3'd4, 32'h0); wr(3'd5, 32'h00); wr(3'd0, 32'hFF); wr(3'd3, 32'h00);

    cur_req = "R5";
    for (int p = 0; p < 8; p++) begin
      wr(3'(p % 4), 32'(p * 8'h29));
      rd(3'(p % 4));
    end

    cur_req = "R9";
    wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'h0); rd(3'd6); rd(3'd7);

    cur_req = "R6";
    wr(3'd4, CODE); wr(3'd5, 32'hFF);
    for (int p = 0; p < 4; p++) begin
      wr(3'(p), 32'hA5 ^ 32'(p));
      rd(3'(p));
    end

    cur_req = "R1";
    do_reset();
    rd(3'd4); check("R1 key closed after reset", rdata, 32'd1);
    rd(3'd0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule